// File: doc/BRIEF.md
# Half-Operand Modifier Operand Fetch Stage

This block is the operand fetch stage of a pipelined SIMD datapath. It holds a register file of `2**ADDR_W` entries, each `2**LOG2_W` bits wide. On each accepted request it reads two source registers. It rewrites each of them field by field under a per-operand half-selection modifier and then hands both operands to the execute stage one cycle later.

A shared field-width code `fw_code` = k selects fields of n = 2**k bits. Each operand has its own address and its own pair of modifier bits. With `*_hi` set, every field is replaced by its upper n/2 bits moved down and zero-extended. With `*_lo` set, every field keeps its lower n/2 bits and has its upper half cleared. With neither set, the operand passes through unchanged.

Requests enter over a valid/ready handshake (`req_valid`/`req_ready`), and operands leave over another (`op_valid`/`op_ready`). A request is taken on a rising edge where `req_valid && req_ready`. `req_ready` is high whenever the output slot is empty or is being drained in that same cycle. While `op_valid` is high and `op_ready` is low, the output slot is frozen and no request is taken. The write-back port is plain: it writes whenever `wr_en` is high, independent of either handshake.

Top module: `hom_fetch`

## Requirements
- R1: After reset, `op_valid` is 0, `req_ready` is 1 and every register reads as zero.
- R2: With both modifier bits of an operand at 0, the operand equals the register contents.
- R3: With `hi`=1 and `lo`=0 and k ≥ 1, every n-bit field (bits [f*n+n-1 : f*n]) becomes its upper n/2 bits, placed at the field's low end with the upper n/2 bits zero.
- R4: With `lo`=1 and `hi`=0 and k ≥ 1, every n-bit field keeps its lower n/2 bits and its upper n/2 bits become zero.
- R5: With `fw_code`=0 (n = 1), a single asserted modifier leaves the operand unmodified.
- R6: With both `hi` and `lo` asserted, the operand passes unmodified and its error output (`op_a_err`/`op_b_err`) is 1. Otherwise that error output is 0.
- R7: An accepted request yields `op_valid`=1 with its operands on the very next rising edge.
- R8: While `op_valid`=1 and `op_ready`=0, `req_ready` is 0 and `op_a`, `op_b` and the error outputs hold their values, even if registers are written meanwhile.
- R9: A request accepted in the same cycle as a write to one of its source addresses returns the newly written data.
- R10: A write with `wr_en`=1 updates the addressed register for all later reads, whether or not a request is in flight.
- R11: The two operands use their own address and modifier bits independently, under the shared `fw_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| src_a_addr | input | ADDR_W | Register address, operand A |
| src_a_hi | input | 1 | Select upper halves, operand A |
| src_a_lo | input | 1 | Select lower halves, operand A |
| src_b_addr | input | ADDR_W | Register address, operand B |
| src_b_hi | input | 1 | Select upper halves, operand B |
| src_b_lo | input | 1 | Select lower halves, operand B |
| fw_code | input | $clog2(LOG2_W+1) | Field width exponent k, n = 2**k |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | ADDR_W | Write-back address |
| wr_data | input | 2**LOG2_W | Write-back data |
| op_valid | output | 1 | Operands present |
| op_ready | input | 1 | Execute stage takes operands |
| op_a | output | 2**LOG2_W | Modified operand A |
| op_b | output | 2**LOG2_W | Modified operand B |
| op_a_err | output | 1 | Operand A had both modifier bits set |
| op_b_err | output | 1 | Operand B had both modifier bits set |

## Verification
A write-back and a read of the same register can fall in the same cycle. A write can also land while the output slot is stalled. The bench provokes the first by raising `wr_en` and `req_valid` in the same low phase with matching addresses, and requires the returned operand to carry the new data. It provokes the second by writing a register whose value sits in the frozen slot, and requires that slot to stay unchanged until `op_ready` rises. Every other result is judged against a field-by-field arithmetic model. That model sweeps all field widths, modifier pairs and data values of an 8-bit, 4-register configuration.

// File: rtl/hom_pkg.sv
package hom_pkg;
  typedef enum logic [1:0] {
    HM_PASS = 2'd0,
    HM_UPPER = 2'd1,
    HM_LOWER = 2'd2,
    HM_BAD = 2'd3
  } hm_sel_e;

  function automatic hm_sel_e hm_decode(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return HM_UPPER;
      2'b01:   return HM_LOWER;
      2'b11:   return HM_BAD;
      default: return HM_PASS;
    endcase
  endfunction
endpackage

// File: rtl/hom_regfile.sv
module hom_regfile #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int NRD = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // read ports: same-cycle write to the same address is forwarded
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (we && waddr == raddr[p]) ? wdata : regs[raddr[p]];
  end
endmodule

// File: rtl/hom_halfmod.sv
module hom_halfmod #(
  parameter int LOG2_W = 5,
  parameter int DATA_W = 1 << LOG2_W,
  parameter int FW_W = $clog2(LOG2_W + 1)
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [FW_W-1:0]   fw,
  input  logic              hi,
  input  logic              lo,
  output logic [DATA_W-1:0] cooked,
  output logic              bad
);
  import hom_pkg::*;

  function automatic logic [DATA_W-1:0] low_half_mask(input int half);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i / half) % 2) == 0;
    return m;
  endfunction

  logic [DATA_W-1:0] up_v [LOG2_W+1];
  logic [DATA_W-1:0] dn_v [LOG2_W+1];

  assign up_v[0] = raw;
  assign dn_v[0] = raw;

  for (genvar k = 1; k <= LOG2_W; k++) begin : g_width
    localparam int HALF = 1 << (k - 1);
    localparam logic [DATA_W-1:0] MASK = low_half_mask(HALF);
    assign up_v[k] = (raw >> HALF) & MASK;
    assign dn_v[k] = raw & MASK;
  end

  hm_sel_e sel;

  always_comb begin
    sel    = hm_decode(hi, lo);
    bad    = (sel == HM_BAD);
    cooked = raw;
    if (int'(fw) <= LOG2_W) begin
      case (sel)
        HM_UPPER: cooked = up_v[fw];
        HM_LOWER: cooked = dn_v[fw];
        default:  cooked = raw;
      endcase
    end
  end
endmodule

// File: rtl/hom_fetch.sv
module hom_fetch #(
  parameter int ADDR_W = 3,
  parameter int LOG2_W = 5,
  localparam int DATA_W = 1 << LOG2_W,
  localparam int FW_W = $clog2(LOG2_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] src_a_addr,
  input  logic              src_a_hi,
  input  logic              src_a_lo,
  input  logic [ADDR_W-1:0] src_b_addr,
  input  logic              src_b_hi,
  input  logic              src_b_lo,
  input  logic [FW_W-1:0]   fw_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic              op_a_err,
  output logic              op_b_err
);
  localparam int NSRC = 2;

  logic                          take;
  logic [NSRC-1:0][ADDR_W-1:0]   rd_addr;
  logic [NSRC-1:0][DATA_W-1:0]   rd_data;
  logic [NSRC-1:0][DATA_W-1:0]   mod_data;
  logic [NSRC-1:0]               hi_v, lo_v, bad_v;

  assign req_ready = !op_valid || op_ready;
  assign take      = req_valid && req_ready;

  assign rd_addr = {src_b_addr, src_a_addr};
  assign hi_v    = {src_b_hi, src_a_hi};
  assign lo_v    = {src_b_lo, src_a_lo};

  hom_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NSRC)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hom_halfmod #(.LOG2_W(LOG2_W), .DATA_W(DATA_W), .FW_W(FW_W)) u_mod (
      .raw    (rd_data[s]),
      .fw     (fw_code),
      .hi     (hi_v[s]),
      .lo     (lo_v[s]),
      .cooked (mod_data[s]),
      .bad    (bad_v[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_a     <= '0;
      op_b     <= '0;
      op_a_err <= 1'b0;
      op_b_err <= 1'b0;
    end else if (take) begin
      op_valid <= 1'b1;
      op_a     <= mod_data[0];
      op_b     <= mod_data[1];
      op_a_err <= bad_v[0];
      op_b_err <= bad_v[1];
    end else if (op_ready) begin
      op_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hom_fetch_chk.sv
module hom_fetch_chk #(
  parameter int ADDR_W = 3,
  parameter int LOG2_W = 5,
  localparam int DATA_W = 1 << LOG2_W,
  localparam int FW_W = $clog2(LOG2_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] src_a_addr,
  input logic              src_a_hi,
  input logic              src_a_lo,
  input logic [ADDR_W-1:0] src_b_addr,
  input logic              src_b_hi,
  input logic              src_b_lo,
  input logic [FW_W-1:0]   fw_code,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_valid,
  input logic              op_ready,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              op_a_err,
  input logic              op_b_err
);
  localparam int HALF_W = DATA_W / 2;

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> op_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_a) && $stable(op_b) && $stable(op_a_err)); // R8
  AST_BOTH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && src_a_hi && src_a_lo |=> op_a_err); // R6
  AST_SINGLE_UNFLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !(src_b_hi && src_b_lo) |=> !op_b_err); // R6
  AST_UPPER_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && src_a_hi && !src_a_lo && int'(fw_code) == LOG2_W
    |=> op_a[DATA_W-1:HALF_W] == '0); // R3
  AST_UPPER_ZERO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && src_b_lo && !src_b_hi && int'(fw_code) == LOG2_W
    |=> op_b[DATA_W-1:HALF_W] == '0); // R4
endmodule

bind hom_fetch hom_fetch_chk #(.ADDR_W(ADDR_W), .LOG2_W(LOG2_W)) u_chk (.*);

// File: tb/hom_fetch_test.sv
`timescale 1ns/1ps
module hom_fetch_test;
  localparam int AW = 2;
  localparam int KW = 3;
  localparam int DW = 1 << KW;
  localparam int NR = 1 << AW;
  localparam int FWW = $clog2(KW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] src_a_addr = '0, src_b_addr = '0, wr_addr = '0;
  logic src_a_hi = 0, src_a_lo = 0, src_b_hi = 0, src_b_lo = 0;
  logic [FWW-1:0] fw_code = '0;
  logic wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic op_valid, op_ready = 1'b1;
  logic [DW-1:0] op_a, op_b;
  logic op_a_err, op_b_err;

  int checks = 0, fails = 0;
  logic [DW-1:0] shadow [NR];

  always #5 clk = ~clk;

  hom_fetch #(.ADDR_W(AW), .LOG2_W(KW)) uut (.*);

  function automatic logic [DW-1:0] model(input logic [DW-1:0] x, input int fw,
                                          input bit h, input bit l);
    int n, half, fld, v, r;
    if (fw == 0 || (h == l)) return x;
    n = 1 << fw; half = n / 2; r = 0;
    for (int f = 0; f < DW / n; f++) begin
      fld = (int'(x) >> (f * n)) % (1 << n);
      v = h ? fld / (1 << half) : fld % (1 << half);
      r = r + (v << (f * n));
    end
    return r[DW-1:0];
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a[AW-1:0]; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    shadow[a] = d;
  endtask

  task automatic rq(input int a, input bit ah, input bit al, input int b,
                    input bit bh, input bit bl, input int fw, input string tag);
    req_valid = 1; src_a_addr = a[AW-1:0]; src_b_addr = b[AW-1:0];
    src_a_hi = ah; src_a_lo = al; src_b_hi = bh; src_b_lo = bl;
    fw_code = fw[FWW-1:0];
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(int'(op_valid), 1, {tag, " R7 valid"});
    chk(int'(op_a), int'(model(shadow[a], fw, ah, al)), {tag, " R11 op_a"});
    chk(int'(op_b), int'(model(shadow[b], fw, bh, bl)), {tag, " R11 op_b"});
    chk(int'(op_a_err), int'(ah && al), {tag, " R6 err_a"});
    chk(int'(op_b_err), int'(bh && bl), {tag, " R6 err_b"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, registers zero
    chk(int'(op_valid), 0, "R1 op_valid");
    chk(int'(req_ready), 1, "R1 req_ready");
    rq(1, 0, 0, 2, 0, 0, 3, "R1 zero regs");

    // R2 R3 R4 R5 R6: every value, width and modifier pair on both operands
    for (int v = 0; v < 256; v++) begin
      wr(0, v[DW-1:0]);
      wr(3, ~v[DW-1:0]);
      for (int fw = 0; fw <= KW; fw++)
        for (int m = 0; m < 4; m++)
          rq(0, m[1], m[0], 3, m[0], !m[1], fw, "R3 R4 R5 sweep");
    end

    // R9: read and write same register in same cycle
    wr(2, 8'h5A);
    wr_en = 1; wr_addr = 2; wr_data = 8'hC3;
    req_valid = 1; src_a_addr = 2; src_b_addr = 1;
    src_a_hi = 0; src_a_lo = 0; src_b_hi = 0; src_b_lo = 0; fw_code = 2;
    @(posedge clk); @(negedge clk);
    wr_en = 0; req_valid = 0; shadow[2] = 8'hC3;
    chk(int'(op_a), 8'hC3, "R9 bypass");
    // R10: persists for later read
    rq(1, 0, 1, 2, 1, 0, 2, "R10 later read");

    // R8: stall holds output while a write lands
    wr(1, 8'h96);
    op_ready = 0;
    rq(1, 1, 0, 0, 0, 0, 2, "R8 enter stall");
    req_valid = 1; src_a_addr = 3; src_a_hi = 0; src_a_lo = 0;
    src_b_addr = 3; src_b_hi = 0; src_b_lo = 0;
    chk(int'(req_ready), 0, "R8 req_ready low");
    wr(1, 8'h11);
    @(posedge clk); @(negedge clk);
    chk(int'(op_a), int'(model(8'h96, 2, 1, 0)), "R8 op_a held");
    chk(int'(op_valid), 1, "R8 op_valid held");
    op_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(int'(op_a), int'(shadow[3]), "R8 next after release");
    @(posedge clk); @(negedge clk);
    chk(int'(op_valid), 0, "R7 drained");
    rq(1, 0, 0, 1, 0, 0, 0, "R10 write during stall");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule